// File: doc/BRIEF.md
# NAND command and address sequencer

This block takes a single request (an opcode, an optional column offset, an optional page number, a flag for large devices and a flag for whether a ready/busy line is wired) and plays it out on a small-page NAND device as an ordered series of byte beats. Command beats go out with the command-latch line high. Address beats go out with the address-latch line high. A byte-transfer engine downstream owns the strobe timing and acknowledges each beat. After the last beat, the sequencer holds until the opcode's completion rule is met, then pulses `done`.

A sequential-load request (opcode 0x80) is always preceded by a pointer opcode that selects the first half, second half or spare area of the page. The column is rebased into that region. The same opcode opens the write-unprotect control, and a program-confirm opcode (0x10) closes it. Read-type and reset opcodes wait on the ready line when one is present. Without a ready line, reads wait a fixed delay and reset polls the device status byte.

Top module: `nand_cmd_seq`

## Requirements
- R1: Before opcode 0x80 the first beat is pointer opcode 0x00 when the column is below 256 or no column is given, and the column byte sent is the column unchanged.
- R2: Before opcode 0x80 with a column from 256 up to PAGE_BYTES-1, the pointer opcode is 0x01 and the column byte sent is column-256.
- R3: Before opcode 0x80 with a column of PAGE_BYTES or more, the pointer opcode is 0x50 and the column byte sent is column-PAGE_BYTES. For any other opcode, the column byte is the low 8 bits of the column.
- R4: Opcode beats carry CLE=1 and ALE=0. Address beats carry ALE=1 and CLE=0. The two lines are never high together, and a beat's byte and lines stay stable until it is acknowledged.
- R5: Address beats follow the order column, page[7:0], page[15:8], then {4'b0, page[19:16]} only when the large-device flag is set. A field whose valid flag is clear gives no beat, and a request with neither field gives no ALE beat.
- R6: `wr_unprot` is 0 after reset. Opcode 0x80 sets it and opcode 0x10 clears it. Every other opcode leaves it unchanged.
- R7: Opcodes 0x80, 0x10, 0x60, 0xD0 and 0x70 finish without regard to the ready line.
- R8: Opcode 0xFF with a ready line present finishes only after `rb_ready` is high.
- R9: Opcode 0xFF with no ready line sends opcode 0x70 once, then reads status bytes until one has bit 6 set, and then finishes.
- R10: Any other opcode waits for `rb_ready` when a ready line is present. Otherwise it finishes between CLK_MHZ*DELAY_US and CLK_MHZ*DELAY_US+4 cycles after its last beat is acknowledged.
- R11: `done` is high for exactly one cycle per request. `req_ready` is high only when idle, and a request presented while busy is ignored.
- R12: After reset, `req_ready`=1 and `xfer_valid`, `xfer_cle`, `xfer_ale`, `done` and `wr_unprot` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Sequencer idle |
| req_cmd | input | 8 | Opcode |
| req_col | input | COL_W | Column offset |
| req_col_vld | input | 1 | Column present |
| req_page | input | PAGE_W | Page number |
| req_page_vld | input | 1 | Page present |
| req_big_dev | input | 1 | Large device: add fourth address beat |
| req_rb_present | input | 1 | Ready/busy line is wired |
| rb_ready | input | 1 | Device ready (synchronous) |
| xfer_valid | output | 1 | Beat pending at byte-transfer engine |
| xfer_rd | output | 1 | Beat is a read |
| xfer_wdata | output | 8 | Byte to write |
| xfer_cle | output | 1 | Command latch for this beat |
| xfer_ale | output | 1 | Address latch for this beat |
| xfer_done | input | 1 | Beat acknowledged |
| xfer_rdata | input | 8 | Read byte, valid with `xfer_done` |
| wr_unprot | output | 1 | Write-unprotect control |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest path to reach is reset recovery with no ready line. There the only exit is a status byte with bit 6 set, so the bench's device model answers a set number of polls with 0x80 (bit 7 set, bit 6 clear) before it answers 0xC0. This proves both the repeat loop and the choice of bit. The second difficult case is a request that arrives mid-operation. The bench sends it while the sequencer is parked on a low ready line, and then checks that the beat log holds only the first sequence and stays quiet afterwards.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam logic [7:0] OP_PTR_LO    = 8'h00;
    localparam logic [7:0] OP_PTR_HI    = 8'h01;
    localparam logic [7:0] OP_PTR_SPARE = 8'h50;
    localparam logic [7:0] OP_LOAD      = 8'h80;
    localparam logic [7:0] OP_PROG      = 8'h10;
    localparam logic [7:0] OP_ERASE_A   = 8'h60;
    localparam logic [7:0] OP_ERASE_B   = 8'hD0;
    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_RESET     = 8'hFF;

    localparam int STATUS_RDY_BIT = 6;
    localparam int HALF_PAGE      = 256;

    typedef enum logic [3:0] {
        S_IDLE, S_PTR, S_CMD, S_COL, S_PG0, S_PG1, S_PG2,
        S_POST, S_WAIT_RB, S_DELAY, S_ST_CMD, S_ST_RD, S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        POL_NONE,
        POL_RB,
        POL_DELAY,
        POL_POLL
    } wait_pol_e;

    // Lines presented with one beat to the byte-transfer engine
    typedef struct packed {
        logic       valid;
        logic       rd;
        logic       cle;
        logic       ale;
        logic [7:0] data;
    } beat_t;

    function automatic wait_pol_e pick_policy(input logic [7:0] op, input logic rb_present);
        wait_pol_e p;
        case (op)
            OP_LOAD, OP_PROG, OP_ERASE_A, OP_ERASE_B, OP_STATUS: p = POL_NONE;
            OP_RESET: p = rb_present ? POL_RB : POL_POLL;
            default:  p = rb_present ? POL_RB : POL_DELAY;
        endcase
        return p;
    endfunction

    function automatic logic is_cmd_state(input seq_state_e s);
        return (s == S_PTR) || (s == S_CMD) || (s == S_ST_CMD);
    endfunction

    function automatic logic is_addr_state(input seq_state_e s);
        return (s == S_COL) || (s == S_PG0) || (s == S_PG1) || (s == S_PG2);
    endfunction

endpackage

// File: rtl/nseq_pointer.sv
module nseq_pointer
    import nseq_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int PAGE_BYTES = 512
) (
    input  logic [COL_W-1:0] col,
    input  logic             col_vld,
    input  logic             is_load,
    output logic [7:0]       ptr_op,
    output logic [7:0]       col_byte
);

    localparam logic [COL_W-1:0] DATA_END = COL_W'(PAGE_BYTES);
    localparam logic [COL_W-1:0] HALF_END = COL_W'(HALF_PAGE);

    logic [COL_W-1:0] rebased;

    always_comb begin
        ptr_op  = OP_PTR_LO;
        rebased = col;
        if (is_load && col_vld) begin
            if (col >= DATA_END) begin
                ptr_op  = OP_PTR_SPARE;
                rebased = col - DATA_END;
            end else if (col >= HALF_END) begin
                ptr_op  = OP_PTR_HI;
                rebased = col - HALF_END;
            end
        end
    end

    assign col_byte = rebased[7:0];

    logic unused_rebased_hi;
    assign unused_rebased_hi = ^rebased;

endmodule

// File: rtl/nseq_delay.sv
module nseq_delay #(
    parameter int DELAY_CYC = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);

    generate
        if (DELAY_CYC == 0) begin : g_none
            logic unused_start;
            assign unused_start = start ^ clk ^ rst;
            assign expired = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DELAY_CYC + 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (start) begin
                    cnt <= CW'(DELAY_CYC);
                end else if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end
            assign expired = (cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/nseq_fsm.sv
module nseq_fsm
    import nseq_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int PAGE_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_cmd,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_col_vld,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              req_page_vld,
    input  logic              req_big_dev,
    input  logic              req_rb_present,
    input  logic              rb_ready,
    output logic [COL_W-1:0]  col_q,
    output logic              col_vld_q,
    output logic              is_load,
    input  logic [7:0]        ptr_op,
    input  logic [7:0]        col_byte,
    output logic              dly_start,
    input  logic              dly_expired,
    output beat_t             beat,
    input  logic              xfer_done,
    input  logic [7:0]        xfer_rdata,
    output logic              wr_unprot,
    output logic              done
);

    localparam int PE_W = (PAGE_W > 20) ? PAGE_W : 20;

    seq_state_e        state;
    logic [7:0]        cmd_q;
    logic [PAGE_W-1:0] page_q;
    logic              page_vld_q;
    logic              big_q;
    logic              rbp_q;
    wait_pol_e         pol;
    logic [PE_W-1:0]   page_ext;

    assign page_ext = PE_W'(page_q);
    assign pol      = pick_policy(cmd_q, rbp_q);
    assign is_load  = (cmd_q == OP_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cmd_q      <= '0;
            col_q      <= '0;
            col_vld_q  <= 1'b0;
            page_q     <= '0;
            page_vld_q <= 1'b0;
            big_q      <= 1'b0;
            rbp_q      <= 1'b0;
            wr_unprot  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cmd_q      <= req_cmd;
                        col_q      <= req_col;
                        col_vld_q  <= req_col_vld;
                        page_q     <= req_page;
                        page_vld_q <= req_page_vld;
                        big_q      <= req_big_dev;
                        rbp_q      <= req_rb_present;
                        state      <= (req_cmd == OP_LOAD) ? S_PTR : S_CMD;
                    end
                end
                S_PTR: if (xfer_done) state <= S_CMD;
                S_CMD: begin
                    if (xfer_done) begin
                        if (col_vld_q)       state <= S_COL;
                        else if (page_vld_q) state <= S_PG0;
                        else                 state <= S_POST;
                    end
                end
                S_COL: if (xfer_done) state <= page_vld_q ? S_PG0 : S_POST;
                S_PG0: if (xfer_done) state <= S_PG1;
                S_PG1: if (xfer_done) state <= big_q ? S_PG2 : S_POST;
                S_PG2: if (xfer_done) state <= S_POST;
                S_POST: begin
                    if (cmd_q == OP_LOAD)      wr_unprot <= 1'b1;
                    else if (cmd_q == OP_PROG) wr_unprot <= 1'b0;
                    case (pol)
                        POL_RB:    state <= S_WAIT_RB;
                        POL_DELAY: state <= S_DELAY;
                        POL_POLL:  state <= S_ST_CMD;
                        default:   state <= S_DONE;
                    endcase
                end
                S_WAIT_RB: if (rb_ready)    state <= S_DONE;
                S_DELAY:   if (dly_expired) state <= S_DONE;
                S_ST_CMD:  if (xfer_done)   state <= S_ST_RD;
                S_ST_RD: begin
                    if (xfer_done && xfer_rdata[STATUS_RDY_BIT]) state <= S_DONE;
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Beat presented for the current state
    always_comb begin
        beat       = '0;
        beat.cle   = is_cmd_state(state);
        beat.ale   = is_addr_state(state);
        beat.rd    = (state == S_ST_RD);
        beat.valid = beat.cle | beat.ale | beat.rd;
        case (state)
            S_PTR:    beat.data = ptr_op;
            S_CMD:    beat.data = cmd_q;
            S_COL:    beat.data = col_byte;
            S_PG0:    beat.data = page_ext[7:0];
            S_PG1:    beat.data = page_ext[15:8];
            S_PG2:    beat.data = {4'b0000, page_ext[19:16]};
            S_ST_CMD: beat.data = OP_STATUS;
            default:  beat.data = 8'h00;
        endcase
    end

    assign dly_start = (state == S_POST) && (pol == POL_DELAY);
    assign req_ready = (state == S_IDLE);
    assign done      = (state == S_DONE);

    logic unused_fsm;
    assign unused_fsm = ^{xfer_rdata, page_ext};

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nseq_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int PAGE_W     = 20,
    parameter int PAGE_BYTES = 512,
    parameter int CLK_MHZ    = 250,
    parameter int DELAY_US   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_cmd,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_col_vld,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              req_page_vld,
    input  logic              req_big_dev,
    input  logic              req_rb_present,
    input  logic              rb_ready,
    output logic              xfer_valid,
    output logic              xfer_rd,
    output logic [7:0]        xfer_wdata,
    output logic              xfer_cle,
    output logic              xfer_ale,
    input  logic              xfer_done,
    input  logic [7:0]        xfer_rdata,
    output logic              wr_unprot,
    output logic              done
);

    localparam int DELAY_CYC = CLK_MHZ * DELAY_US;

    logic [COL_W-1:0] col_q;
    logic             col_vld_q;
    logic             is_load;
    logic [7:0]       ptr_op;
    logic [7:0]       col_byte;
    logic             dly_start;
    logic             dly_expired;
    beat_t            beat;

    nseq_pointer #(
        .COL_W      (COL_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_ptr (
        .col      (col_q),
        .col_vld  (col_vld_q),
        .is_load  (is_load),
        .ptr_op   (ptr_op),
        .col_byte (col_byte)
    );

    nseq_delay #(
        .DELAY_CYC (DELAY_CYC)
    ) u_dly (
        .clk     (clk),
        .rst     (rst),
        .start   (dly_start),
        .expired (dly_expired)
    );

    nseq_fsm #(
        .COL_W  (COL_W),
        .PAGE_W (PAGE_W)
    ) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_cmd        (req_cmd),
        .req_col        (req_col),
        .req_col_vld    (req_col_vld),
        .req_page       (req_page),
        .req_page_vld   (req_page_vld),
        .req_big_dev    (req_big_dev),
        .req_rb_present (req_rb_present),
        .rb_ready       (rb_ready),
        .col_q          (col_q),
        .col_vld_q      (col_vld_q),
        .is_load        (is_load),
        .ptr_op         (ptr_op),
        .col_byte       (col_byte),
        .dly_start      (dly_start),
        .dly_expired    (dly_expired),
        .beat           (beat),
        .xfer_done      (xfer_done),
        .xfer_rdata     (xfer_rdata),
        .wr_unprot      (wr_unprot),
        .done           (done)
    );

    assign xfer_valid = beat.valid;
    assign xfer_rd    = beat.rd;
    assign xfer_cle   = beat.cle;
    assign xfer_ale   = beat.ale;
    assign xfer_wdata = beat.data;

endmodule

// File: rtl/nseq_checker.sv
module nseq_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic       xfer_valid,
    input logic       xfer_done,
    input logic [7:0] xfer_wdata,
    input logic       xfer_cle,
    input logic       xfer_ale,
    input logic       wr_unprot,
    input logic       done
);

    assert_cle_ale_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(xfer_cle && xfer_ale));

    assert_beat_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_done) |=>
            (xfer_valid && $stable(xfer_wdata) && $stable(xfer_cle) && $stable(xfer_ale)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_to_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!xfer_valid && !done));

    assert_unprot_busy_only_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(wr_unprot) |-> !req_ready);

endmodule

bind nand_cmd_seq nseq_checker u_nseq_checker (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .xfer_valid (xfer_valid),
    .xfer_done  (xfer_done),
    .xfer_wdata (xfer_wdata),
    .xfer_cle   (xfer_cle),
    .xfer_ale   (xfer_ale),
    .wr_unprot  (wr_unprot),
    .done       (done)
);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;

    localparam int COLW = 10;
    localparam int PGW  = 20;
    localparam int PGB  = 512;
    localparam int MHZ  = 2;
    localparam int DUS  = 20;
    localparam int DLY  = MHZ * DUS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [7:0]      req_cmd = '0;
    logic [COLW-1:0] req_col = '0;
    logic            req_col_vld = 1'b0;
    logic [PGW-1:0]  req_page = '0;
    logic            req_page_vld = 1'b0;
    logic            req_big_dev = 1'b0;
    logic            req_rb_present = 1'b0;
    logic            rb_ready = 1'b1;
    logic            xfer_valid, xfer_rd, xfer_cle, xfer_ale;
    logic [7:0]      xfer_wdata;
    logic            xfer_done;
    logic [7:0]      xfer_rdata;
    logic            wr_unprot, done;

    nand_cmd_seq #(
        .COL_W(COLW), .PAGE_W(PGW), .PAGE_BYTES(PGB), .CLK_MHZ(MHZ), .DELAY_US(DUS)
    ) u_nand_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_col(req_col), .req_col_vld(req_col_vld),
        .req_page(req_page), .req_page_vld(req_page_vld), .req_big_dev(req_big_dev),
        .req_rb_present(req_rb_present), .rb_ready(rb_ready),
        .xfer_valid(xfer_valid), .xfer_rd(xfer_rd), .xfer_wdata(xfer_wdata),
        .xfer_cle(xfer_cle), .xfer_ale(xfer_ale), .xfer_done(xfer_done),
        .xfer_rdata(xfer_rdata), .wr_unprot(wr_unprot), .done(done)
    );

    int     vec_n = 0;
    int     bad_n = 0;
    longint cyc_g = 0;
    always @(posedge clk) cyc_g <= cyc_g + 1;

    // Device model: acknowledges beats, logs {rd,cle,ale,byte}
    int          lat = 0, gap = 0, poll_cnt = 0, poll_need = 0;
    logic [10:0] log_e [32];
    int          log_n = 0;
    longint      last_ack = 0;
    longint      done_at = 0;

    initial begin
        xfer_done  = 1'b0;
        xfer_rdata = 8'h00;
        forever begin
            @(negedge clk);
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (xfer_valid) begin
                if (gap >= lat) begin
                    gap = 0;
                    if (xfer_rd) begin
                        xfer_rdata = (poll_cnt >= poll_need) ? 8'hC0 : 8'h80;
                        poll_cnt++;
                    end
                    if (log_n < 32)
                        log_e[log_n] = {xfer_rd, xfer_cle, xfer_ale, xfer_rd ? xfer_rdata : xfer_wdata};
                    log_n++;
                    last_ack  = cyc_g;
                    xfer_done = 1'b1;
                end else begin
                    gap++;
                end
            end
        end
    end

    logic [10:0] exp_e [32];
    int          exp_n = 0;

    task automatic push(input logic [10:0] e);
        if (exp_n < 32) exp_e[exp_n] = e;
        exp_n++;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        vec_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    endtask

    // Expected beat list from the requirements
    task automatic build_exp(input logic [7:0] cmd, input int col, input bit colv,
                             input int page, input bit pagev, input bit big,
                             input bit rbp, input int polls);
        int c;
        exp_n = 0;
        c = col;
        if (cmd == 8'h80) begin
            if (colv && col >= PGB) begin
                push({3'b010, 8'h50}); c = col - PGB;
            end else if (colv && col >= 256) begin
                push({3'b010, 8'h01}); c = col - 256;
            end else begin
                push({3'b010, 8'h00});
            end
        end
        push({3'b010, cmd});
        if (colv)  push({3'b001, 8'(c % 256)});
        if (pagev) begin
            push({3'b001, 8'(page % 256)});
            push({3'b001, 8'((page / 256) % 256)});
            if (big) push({3'b001, 8'((page / 65536) % 16)});
        end
        if (cmd == 8'hFF && !rbp) begin
            push({3'b010, 8'h70});
            for (int i = 0; i < polls; i++) push({3'b100, 8'h80});
            push({3'b100, 8'hC0});
        end
    endtask

    task automatic run_req(input logic [7:0] cmd, input int col, input bit colv,
                           input int page, input bit pagev, input bit big,
                           input bit rbp, input int rb_rel, input int polls,
                           input int inj, input string tag, output int dcyc);
        bit got;
        build_exp(cmd, col, colv, page, pagev, big, rbp, polls);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        log_n = 0; poll_cnt = 0; poll_need = polls; gap = 0;
        if (rb_rel > 0) rb_ready = 1'b0;
        req_cmd = cmd; req_col = COLW'(col); req_col_vld = colv;
        req_page = PGW'(page); req_page_vld = pagev; req_big_dev = big;
        req_rb_present = rbp; req_valid = 1'b1;
        dcyc = 0; got = 0;
        while (!got && dcyc < 3000) begin
            @(negedge clk);
            req_valid = 1'b0;
            dcyc++;
            if (rb_rel > 0 && dcyc == rb_rel) rb_ready = 1'b1;
            if (inj > 0 && dcyc == inj) begin
                req_cmd = 8'h60; req_valid = 1'b1;
            end
            if (done) begin got = 1; done_at = cyc_g; end
        end
        rb_ready = 1'b1;
        req_valid = 1'b0;
        chk(got, tag, "done seen", got, 1);
        @(negedge clk);
        chk(!done, "R11", "done width one cycle", done, 0);
        if (log_n != exp_n) begin
            chk(0, tag, "beat count", log_n, exp_n);
        end else begin
            int bad_i;
            bad_i = -1;
            for (int i = 0; i < exp_n; i++)
                if (bad_i < 0 && log_e[i] != exp_e[i]) bad_i = i;
            if (bad_i < 0) chk(1, tag, "beats", 0, 0);
            else           chk(0, tag, "beat {rd,cle,ale,byte}", log_e[bad_i], exp_e[bad_i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_n++;
        $display("FAIL R11 watchdog expired actual=0 expected=1");
        summary();
        $finish;
    end

    initial begin
        int d;
        int cols [11] = '{0, 1, 100, 255, 256, 257, 400, 511, 512, 513, 527};
        string t;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(req_ready == 1'b1, "R12", "req_ready", req_ready, 1);
        chk({xfer_valid, xfer_cle, xfer_ale, done, wr_unprot} == 5'b0, "R12",
            "outputs quiet", {xfer_valid, xfer_cle, xfer_ale, done, wr_unprot}, 0);

        // Sequential-load sweep over column regions, both device sizes
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 11; k++) begin
                lat = (k + b) % 3;
                if (cols[k] >= PGB)      t = "R3";
                else if (cols[k] >= 256) t = "R2";
                else                     t = "R1";
                run_req(8'h80, cols[k], 1, 20'hA5000 + k * 4099, 1, b[0], 0, 1000, 0, 0, t, d);
                chk(d < 1000, "R7", "load ignores ready line", d, 1000);
                chk(wr_unprot == 1'b1, "R6", "unprot after load", wr_unprot, 1);
            end
        end
        lat = 1;
        // Program confirm, no address
        run_req(8'h10, 0, 0, 0, 0, 0, 0, 1000, 0, 0, "R5", d);
        chk(d < 1000, "R7", "program ignores ready line", d, 1000);
        chk(wr_unprot == 1'b0, "R6", "unprot after program", wr_unprot, 0);
        // Load with no column: low pointer
        run_req(8'h80, 0, 0, 20'h3C3C3, 1, 1, 0, 0, 0, 0, "R1", d);
        // Erase start, page only, both sizes; unprot held
        run_req(8'h60, 0, 0, 20'hFEDCB, 1, 0, 0, 1000, 0, 0, "R5", d);
        chk(d < 1000, "R7", "erase start ignores ready line", d, 1000);
        run_req(8'h60, 0, 0, 20'hFEDCB, 1, 1, 0, 1000, 0, 0, "R5", d);
        chk(wr_unprot == 1'b1, "R6", "unprot untouched by erase", wr_unprot, 1);
        run_req(8'hD0, 0, 0, 0, 0, 0, 1, 1000, 0, 0, "R4", d);
        chk(d < 1000, "R7", "erase confirm ignores ready line", d, 1000);
        run_req(8'h70, 0, 0, 0, 0, 0, 0, 1000, 0, 0, "R4", d);
        chk(d < 1000, "R7", "status ignores ready line", d, 1000);
        chk(wr_unprot == 1'b1, "R6", "unprot untouched by status", wr_unprot, 1);
        run_req(8'h10, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6", d);
        chk(wr_unprot == 1'b0, "R6", "unprot closed", wr_unprot, 0);
        // Read with ready line, column above 255 sent raw
        run_req(8'h00, 300, 1, 20'h12345, 1, 1, 1, 40, 0, 0, "R3", d);
        chk(d > 40, "R10", "read waits for ready", d, 41);
        chk(wr_unprot == 1'b0, "R6", "unprot untouched by read", wr_unprot, 0);
        // Read without ready line: fixed delay
        run_req(8'h50, 3, 1, 20'h00777, 1, 0, 0, 0, 0, 0, "R5", d);
        chk((done_at - last_ack) >= DLY && (done_at - last_ack) <= DLY + 4, "R10",
            "fixed delay", done_at - last_ack, DLY);
        run_req(8'h01, 77, 1, 0, 0, 0, 0, 0, 0, 0, "R5", d);
        chk((done_at - last_ack) >= DLY && (done_at - last_ack) <= DLY + 4, "R10",
            "fixed delay column only", done_at - last_ack, DLY);
        // Reset with ready line
        run_req(8'hFF, 0, 0, 0, 0, 0, 1, 25, 0, 0, "R8", d);
        chk(d > 25, "R8", "reset waits for ready", d, 26);
        // Reset without ready line: status polling
        for (int p = 0; p < 5; p += 2) begin
            lat = p % 3;
            run_req(8'hFF, 0, 0, 0, 0, 0, 0, 1000, p, 0, "R9", d);
            chk(d < 1000, "R9", "poll exit without ready line", d, 1000);
        end
        lat = 1;
        // Request while busy is ignored
        run_req(8'h00, 5, 1, 20'h00007, 1, 0, 1, 30, 0, 20, "R11", d);
        repeat (6) @(negedge clk);
        chk(log_n == exp_n, "R11", "no beats from ignored request", log_n, exp_n);
        chk(req_ready == 1'b1, "R11", "idle after ignored request", req_ready, 1);

        summary();
        $finish;
    end

endmodule